// File: doc/BRIEF.md
# Checkpoint Macroblock QP Rate Controller

This block steers the quantizer of a video encoder while a frame is being encoded. The encode pipeline reports each finished macroblock with the number of bits it produced, its MAD value and an error indication. The controller keeps a running bit total. Every time a programmable number of macroblocks has completed, it compares that total with a cumulative target for the current checkpoint. The size of the miss selects a QP step from a seven-level table. The QP moves up when the encoder overshoots and down when it undershoots, and the result is clamped into a programmed QP window.

Separately, any macroblock whose MAD falls below a threshold (given in units of 256) is coded with a signed offset added to the base QP. The block also accumulates frame statistics: half of the sum of the QPs actually used, the count of low-MAD macroblocks, the total macroblock count, the bit total captured at each checkpoint, and a sticky error flag. A `frame_start` pulse restarts everything at the programmed initial QP. All programming inputs are expected to change only together with `frame_start`.

Top module: `cpqp_rate_ctrl`

## Requirements
- R1: After reset, `qp_next`, `qp_sum_half`, `mb_cnt`, `low_mad_cnt`, `enc_err` and every `cp_used` field read 0.
- R2: A `frame_start` pulse has priority over `mb_valid`. On the next cycle, `qp_next` equals `cfg_qp_init` clamped to the QP window, and all statistics, checkpoint captures and the checkpoint index are zero.
- R3: When `cfg_cp_spacing` is 0, `qp_next` never changes within the frame, whatever bits are reported.
- R4: With a nonzero spacing S, a checkpoint falls on every S-th reported macroblock of the frame, up to NUM_CP (10) checkpoints. No further checkpoints occur after that. A new QP is visible on `qp_next` in the cycle after the macroblock that completed the checkpoint.
- R5: At checkpoint k, err = total bits so far (including that macroblock) minus target k. Target k occupies bits [24k+23:24k] of `cfg_cp_target`. The step is `cfg_lvl_dqp[i]` for the highest i with |err| >= `cfg_lvl_err[i]`; level i sits at bits [24i+23:24i] and its step at bits [4i+3:4i]. The step is 0 if no level is reached. It is added when err >= 0 and subtracted otherwise.
- R6: The QP window is [`cfg_qp_min`, min(`cfg_qp_max`, 51)]. Every QP the block produces (initial, after a checkpoint, MAD-adjusted) is clamped to it. Results above the upper bound take the upper bound; results below the lower bound take the lower bound.
- R7: A macroblock with `mb_mad` < `cfg_mad_thr`*256 is low-MAD. Each low-MAD macroblock increments `low_mad_cnt` and uses `qp_mad` = clamp(base QP + `cfg_mad_dqp`), where `cfg_mad_dqp` is two's complement in the range -8 to +7. Every other macroblock uses the base QP.
- R8: `qp_sum_half` equals floor(sum of the QPs used by the frame's macroblocks / 2).
- R9: `mb_cnt` increments by one for each reported macroblock in the frame.
- R10: `cp_used` field k (bits [24k+23:24k]) holds the bit total captured at checkpoint k, and is 0 for checkpoints not yet reached.
- R11: `enc_err` is 0 for a clean frame. It becomes 1 after any reported macroblock with `mb_err` set, and stays 1 until the next `frame_start`.
- R12: In a cycle with neither `mb_valid` nor `frame_start`, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse |
| mb_valid | input | 1 | A macroblock completed this cycle |
| mb_bits | input | 16 | Bits produced by the macroblock |
| mb_mad | input | 16 | MAD of the macroblock |
| mb_err | input | 1 | Macroblock encoded with an error |
| cfg_qp_init | input | 6 | Initial frame QP |
| cfg_qp_min | input | 6 | Lower QP bound |
| cfg_qp_max | input | 6 | Upper QP bound (capped at 51) |
| cfg_cp_spacing | input | 16 | Macroblocks between checkpoints, 0 disables |
| cfg_cp_target | input | 240 | Ten cumulative bit targets, 24 bits each |
| cfg_lvl_err | input | 168 | Seven error levels, 24 bits each, ascending |
| cfg_lvl_dqp | input | 28 | Seven QP step magnitudes, 4 bits each |
| cfg_mad_thr | input | 8 | MAD threshold in units of 256 |
| cfg_mad_dqp | input | 4 | Signed QP offset for low-MAD macroblocks |
| qp_next | output | 6 | Base QP for the next macroblock |
| qp_mad | output | 6 | QP for the next macroblock if it is low-MAD |
| qp_sum_half | output | 21 | Half the sum of used QPs |
| mb_cnt | output | 16 | Macroblocks in the frame |
| low_mad_cnt | output | 16 | Low-MAD macroblocks in the frame |
| cp_used | output | 240 | Bit total captured at each checkpoint |
| enc_err | output | 1 | Frame error flag |

## Verification
The assertions assume that `cfg_qp_min` <= min(`cfg_qp_max`, 51) and that programming inputs change only in a cycle where `frame_start` is high. The QP window check is therefore armed only after the first frame start and skipped in frame-start cycles. The stimulus keeps to this by loading each frame's configuration in the same cycle as its `frame_start` pulse and by using windows that always satisfy the ordering. The step check for a disabled spacing relies on the spacing staying fixed across the cycle it looks at, which the same rule guarantees.

// File: rtl/cpqp_pkg.sv
package cpqp_pkg;
  localparam int QP_CEIL = 51;
  typedef logic [5:0] qp_t;
endpackage

// File: rtl/cpqp_qp_clamp.sv
module cpqp_qp_clamp #(
  parameter int QPW = 6,
  parameter int DW  = 5
) (
  input  logic [QPW-1:0]       base,
  input  logic signed [DW-1:0] delta,
  input  logic [QPW-1:0]       lo,
  input  logic [QPW-1:0]       hi,
  output logic [QPW-1:0]       qp
);
  localparam int SW = ((QPW > DW) ? QPW : DW) + 2;

  logic signed [SW-1:0] sum_s, lo_s, hi_s;

  always_comb begin
    sum_s = $signed(SW'({1'b0, base})) + SW'(delta);
    lo_s  = $signed(SW'({1'b0, lo}));
    hi_s  = $signed(SW'({1'b0, hi}));
    if (sum_s > hi_s)      qp = hi;
    else if (sum_s < lo_s) qp = lo;
    else                   qp = sum_s[QPW-1:0];
  end
endmodule

// File: rtl/cpqp_level_sel.sv
module cpqp_level_sel #(
  parameter int NUM_LVL = 7,
  parameter int TW      = 24,
  parameter int DQW     = 4
) (
  input  logic [TW-1:0]          abs_err,
  input  logic [NUM_LVL*TW-1:0]  lvl_err,
  input  logic [NUM_LVL*DQW-1:0] lvl_dqp,
  output logic [DQW-1:0]         step
);
  always_comb begin
    step = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (abs_err >= lvl_err[i*TW +: TW]) step = lvl_dqp[i*DQW +: DQW];
    end
  end
endmodule

// File: rtl/cpqp_stats.sv
module cpqp_stats #(
  parameter int QPW  = 6,
  parameter int CNTW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              low,
  input  logic              err,
  input  logic [QPW-1:0]    used_qp,
  output logic [CNTW-1:0]   mb_cnt,
  output logic [CNTW-1:0]   low_cnt,
  output logic [QPW+CNTW-2:0] qp_sum_half,
  output logic              enc_err
);
  localparam int SUMW = QPW + CNTW - 1 + 1;

  logic [CNTW-1:0] mb_cnt_q, mb_cnt_d, low_q, low_d;
  logic [SUMW-1:0] sum_q, sum_d;
  logic            err_q, err_d;
  logic            en;

  assign en = clr | inc;

  always_comb begin
    mb_cnt_d = mb_cnt_q;
    low_d    = low_q;
    sum_d    = sum_q;
    err_d    = err_q;
    if (clr) begin
      mb_cnt_d = '0;
      low_d    = '0;
      sum_d    = '0;
      err_d    = 1'b0;
    end else if (inc) begin
      mb_cnt_d = mb_cnt_q + 1'b1;
      low_d    = low_q + CNTW'(low);
      sum_d    = sum_q + SUMW'(used_qp);
      err_d    = err_q | err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_cnt_q <= '0;
      low_q    <= '0;
      sum_q    <= '0;
      err_q    <= 1'b0;
    end else if (en) begin
      mb_cnt_q <= mb_cnt_d;
      low_q    <= low_d;
      sum_q    <= sum_d;
      err_q    <= err_d;
    end
  end

  assign mb_cnt      = mb_cnt_q;
  assign low_cnt     = low_q;
  assign qp_sum_half = sum_q[SUMW-1:1];
  assign enc_err     = err_q;
endmodule

// File: rtl/cpqp_rate_ctrl.sv
module cpqp_rate_ctrl
  import cpqp_pkg::*;
#(
  parameter int NUM_CP  = 10,
  parameter int NUM_LVL = 7,
  parameter int QPW     = 6,
  parameter int BITW    = 16,
  parameter int MADW    = 16,
  parameter int TW      = 24,
  parameter int DQW     = 4,
  parameter int SPW     = 16,
  parameter int CNTW    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   mb_valid,
  input  logic [BITW-1:0]        mb_bits,
  input  logic [MADW-1:0]        mb_mad,
  input  logic                   mb_err,
  input  logic [QPW-1:0]         cfg_qp_init,
  input  logic [QPW-1:0]         cfg_qp_min,
  input  logic [QPW-1:0]         cfg_qp_max,
  input  logic [SPW-1:0]         cfg_cp_spacing,
  input  logic [NUM_CP*TW-1:0]   cfg_cp_target,
  input  logic [NUM_LVL*TW-1:0]  cfg_lvl_err,
  input  logic [NUM_LVL*DQW-1:0] cfg_lvl_dqp,
  input  logic [MADW-9:0]        cfg_mad_thr,
  input  logic [3:0]             cfg_mad_dqp,
  output logic [QPW-1:0]         qp_next,
  output logic [QPW-1:0]         qp_mad,
  output logic [QPW+CNTW-2:0]    qp_sum_half,
  output logic [CNTW-1:0]        mb_cnt,
  output logic [CNTW-1:0]        low_mad_cnt,
  output logic [NUM_CP*TW-1:0]   cp_used,
  output logic                   enc_err
);
  localparam int IDXW = $clog2(NUM_CP + 1);
  localparam logic [IDXW-1:0] CP_END = IDXW'(NUM_CP);
  localparam logic [QPW-1:0]  QP_TOP = QPW'(QP_CEIL);

  logic [QPW-1:0]  qp_q, qp_d;
  logic [TW-1:0]   acc_q, acc_d;
  logic [SPW-1:0]  dist_q, dist_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            state_en;

  logic [QPW-1:0]  hi_eff, qp_init_cl, qp_cp;
  logic [TW-1:0]   acc_sum, tgt_sel, abs_err;
  logic            over, mad_low, cp_hit, cp_on;
  logic [DQW-1:0]  step;
  logic signed [DQW:0] cp_delta;
  logic [QPW-1:0]  used_qp;

  assign hi_eff  = (cfg_qp_max > QP_TOP) ? QP_TOP : cfg_qp_max;
  assign acc_sum = acc_q + TW'(mb_bits);
  assign mad_low = mb_mad < {cfg_mad_thr, 8'h00};
  assign cp_on   = (cfg_cp_spacing != '0);
  assign cp_hit  = mb_valid && cp_on && (idx_q < CP_END) &&
                   (({1'b0, dist_q} + 1'b1) == {1'b0, cfg_cp_spacing});

  always_comb begin
    tgt_sel = '0;
    for (int k = 0; k < NUM_CP; k++) begin
      if (idx_q == IDXW'(k)) tgt_sel = cfg_cp_target[k*TW +: TW];
    end
    over     = (acc_sum >= tgt_sel);
    abs_err  = over ? (acc_sum - tgt_sel) : (tgt_sel - acc_sum);
  end

  cpqp_level_sel #(.NUM_LVL(NUM_LVL), .TW(TW), .DQW(DQW)) i_lvl (
    .abs_err (abs_err),
    .lvl_err (cfg_lvl_err),
    .lvl_dqp (cfg_lvl_dqp),
    .step    (step)
  );

  assign cp_delta = over ? $signed({1'b0, step}) : -$signed({1'b0, step});

  cpqp_qp_clamp #(.QPW(QPW), .DW(DQW + 1)) i_clamp_cp (
    .base (qp_q), .delta (cp_delta), .lo (cfg_qp_min), .hi (hi_eff), .qp (qp_cp)
  );

  cpqp_qp_clamp #(.QPW(QPW), .DW(4)) i_clamp_mad (
    .base (qp_q), .delta ($signed(cfg_mad_dqp)), .lo (cfg_qp_min), .hi (hi_eff), .qp (qp_mad)
  );

  cpqp_qp_clamp #(.QPW(QPW), .DW(2)) i_clamp_init (
    .base (cfg_qp_init), .delta (2'sb00), .lo (cfg_qp_min), .hi (hi_eff), .qp (qp_init_cl)
  );

  assign used_qp = mad_low ? qp_mad : qp_q;

  // Next-state for base QP and checkpoint sequencing
  always_comb begin
    qp_d   = qp_q;
    acc_d  = acc_q;
    dist_d = dist_q;
    idx_d  = idx_q;
    if (frame_start) begin
      qp_d   = qp_init_cl;
      acc_d  = '0;
      dist_d = '0;
      idx_d  = '0;
    end else if (mb_valid) begin
      acc_d = acc_sum;
      if (cp_hit) begin
        qp_d   = qp_cp;
        dist_d = '0;
        idx_d  = idx_q + 1'b1;
      end else if (cp_on) begin
        dist_d = dist_q + 1'b1;
      end
    end
  end

  assign state_en = frame_start | mb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qp_q   <= '0;
      acc_q  <= '0;
      dist_q <= '0;
      idx_q  <= '0;
    end else if (state_en) begin
      qp_q   <= qp_d;
      acc_q  <= acc_d;
      dist_q <= dist_d;
      idx_q  <= idx_d;
    end
  end

  // Per-checkpoint capture of cumulative bits
  for (genvar k = 0; k < NUM_CP; k++) begin : g_cap
    logic [TW-1:0] cap_q, cap_d;
    logic          cap_en;
    assign cap_en = frame_start | (cp_hit && (idx_q == IDXW'(k)));
    assign cap_d  = frame_start ? '0 : acc_sum;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_en) cap_q <= cap_d;
    end
    assign cp_used[k*TW +: TW] = cap_q;
  end

  cpqp_stats #(.QPW(QPW), .CNTW(CNTW)) i_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (frame_start),
    .inc         (mb_valid),
    .low         (mad_low),
    .err         (mb_err),
    .used_qp     (used_qp),
    .mb_cnt      (mb_cnt),
    .low_cnt     (low_mad_cnt),
    .qp_sum_half (qp_sum_half),
    .enc_err     (enc_err)
  );

  assign qp_next = qp_q;
endmodule

// File: rtl/cpqp_chk.sv
module cpqp_chk #(
  parameter int QPW  = 6,
  parameter int SPW  = 16,
  parameter int CNTW = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_start,
  input logic                mb_valid,
  input logic [QPW-1:0]      cfg_qp_min,
  input logic [QPW-1:0]      cfg_qp_max,
  input logic [SPW-1:0]      cfg_cp_spacing,
  input logic [QPW-1:0]      qp_next,
  input logic [QPW+CNTW-2:0] qp_sum_half,
  input logic [CNTW-1:0]     mb_cnt,
  input logic [CNTW-1:0]     low_mad_cnt,
  input logic                enc_err
);
  logic frame_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           frame_seen <= 1'b0;
    else if (frame_start) frame_seen <= 1'b1;
  end

  // R6
  qp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_seen && !frame_start) |->
      (qp_next >= cfg_qp_min) && (qp_next <= cfg_qp_max) && (qp_next <= QPW'(51)));

  // R2
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mb_cnt == '0) && (low_mad_cnt == '0) && (qp_sum_half == '0) && !enc_err);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb_valid && !frame_start) |=>
      $stable(qp_next) && $stable(mb_cnt) && $stable(qp_sum_half) && $stable(enc_err));

  // R9
  mb_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_valid && !frame_start) |=> mb_cnt == CNTW'($past(mb_cnt) + 1'b1));

  // R3
  no_cp_qp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_valid && !frame_start && cfg_cp_spacing == '0) |=> $stable(qp_next));

  // R7
  low_mad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_mad_cnt <= mb_cnt);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_err && !frame_start) |=> enc_err);
endmodule

bind cpqp_rate_ctrl cpqp_chk #(.QPW(QPW), .SPW(SPW), .CNTW(CNTW)) i_chk (.*);

// File: tb/test_cpqp_rate_ctrl.sv
module test_cpqp_rate_ctrl;
  localparam int NCP = 10, NLV = 7, TW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, mb_valid = 1'b0, mb_err = 1'b0;
  logic [15:0] mb_bits = '0, mb_mad = '0;
  logic [5:0]  cfg_qp_init = '0, cfg_qp_min = '0, cfg_qp_max = '0;
  logic [15:0] cfg_cp_spacing = '0;
  logic [NCP*TW-1:0] cfg_cp_target = '0;
  logic [NLV*TW-1:0] cfg_lvl_err = '0;
  logic [NLV*4-1:0]  cfg_lvl_dqp = '0;
  logic [7:0]  cfg_mad_thr = '0;
  logic [3:0]  cfg_mad_dqp = '0;
  logic [5:0]  qp_next, qp_mad;
  logic [20:0] qp_sum_half;
  logic [15:0] mb_cnt, low_mad_cnt;
  logic [NCP*TW-1:0] cp_used;
  logic enc_err;

  cpqp_rate_ctrl i_cpqp_rate_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  int lvl[NLV] = '{0, 40, 120, 250, 450, 700, 1000};
  int m_qp, m_acc, m_cnt, m_sum, m_low, m_idx, m_dist, m_tgt[NCP], m_used[NCP];
  bit m_err;
  int c_min, c_max, c_init, c_sp, c_thr, c_mdq;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampf(int v);
    int hi = (c_max > 51) ? 51 : c_max;
    if (v > hi) return hi;
    if (v < c_min) return c_min;
    return v;
  endfunction

  task automatic start_frame(int init, int mn, int mx, int sp, int thr, int mdq);
    c_init = init; c_min = mn; c_max = mx; c_sp = sp; c_thr = thr; c_mdq = mdq;
    cfg_qp_init = 6'(init); cfg_qp_min = 6'(mn); cfg_qp_max = 6'(mx);
    cfg_cp_spacing = 16'(sp); cfg_mad_thr = 8'(thr); cfg_mad_dqp = 4'(mdq);
    for (int k = 0; k < NCP; k++) begin
      m_tgt[k] = (k + 1) * sp * 100;
      cfg_cp_target[k*TW +: TW] = TW'(m_tgt[k]);
      m_used[k] = 0;
    end
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_qp = clampf(init); m_acc = 0; m_cnt = 0; m_sum = 0; m_low = 0;
    m_idx = 0; m_dist = 0; m_err = 0;
    // R2
    chk("R2 qp_next after frame_start", int'(qp_next), m_qp);
    chk("R2 mb_cnt cleared", int'(mb_cnt), 0);
    chk("R2 cp_used[0] cleared", int'(cp_used[TW-1:0]), 0);
  endtask

  task automatic do_mb(int bits, int mad, bit err);
    int mdqs, eff, e, a, mag;
    bit low;
    mb_valid = 1'b1; mb_bits = 16'(bits); mb_mad = 16'(mad); mb_err = err;
    mdqs = (c_mdq >= 8) ? c_mdq - 16 : c_mdq;
    low = (mad < c_thr * 256);
    eff = low ? clampf(m_qp + mdqs) : m_qp;
    m_sum += eff; m_cnt++; m_low += int'(low); m_acc += bits; m_err |= err;
    if (c_sp != 0) begin
      if (m_idx < NCP && m_dist + 1 == c_sp) begin
        e = m_acc - m_tgt[m_idx];
        a = (e < 0) ? -e : e;
        mag = 0;
        for (int i = 0; i < NLV; i++) if (a >= lvl[i]) mag = i;
        m_qp = clampf(m_qp + ((e >= 0) ? mag : -mag));
        m_used[m_idx] = m_acc;
        m_idx++; m_dist = 0;
      end else m_dist++;
    end
    @(negedge clk);
    mb_valid = 1'b0; mb_err = 1'b0;
    // R4 R5 R6 (R3 when spacing is 0)
    chk(c_sp == 0 ? "R3 qp_next held" : "R5 qp_next after mb", int'(qp_next), m_qp);
    // R7
    chk("R7 qp_mad", int'(qp_mad), clampf(m_qp + ((c_mdq >= 8) ? c_mdq - 16 : c_mdq)));
  endtask

  task automatic end_frame();
    // R9
    chk("R9 mb_cnt", int'(mb_cnt), m_cnt);
    // R7
    chk("R7 low_mad_cnt", int'(low_mad_cnt), m_low);
    // R8
    chk("R8 qp_sum_half", int'(qp_sum_half), m_sum / 2);
    // R11
    chk("R11 enc_err", int'(enc_err), int'(m_err));
    // R10
    for (int k = 0; k < NCP; k++)
      chk("R10 cp_used", int'(cp_used[k*TW +: TW]), m_used[k]);
  endtask

  initial begin
    int sps[5] = '{0, 1, 2, 3, 5};
    int bits, q0;
    for (int i = 0; i < NLV; i++) begin
      cfg_lvl_err[i*TW +: TW] = TW'(lvl[i]);
      cfg_lvl_dqp[i*4 +: 4] = 4'(i);
    end
    repeat (3) @(negedge clk);
    // R1
    chk("R1 qp_next reset", int'(qp_next), 0);
    chk("R1 mb_cnt reset", int'(mb_cnt), 0);
    chk("R1 qp_sum_half reset", int'(qp_sum_half), 0);
    chk("R1 enc_err reset", int'(enc_err), 0);
    chk("R1 cp_used reset", (cp_used == '0) ? 1 : 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 low_mad_cnt reset", int'(low_mad_cnt), 0);

    for (int s = 0; s < 5; s++) begin
      for (int p = 0; p < 4; p++) begin
        start_frame(30, 18, 40, sps[s], 8, (p % 2) ? 5 : 13);
        for (int i = 0; i < 40; i++) begin
          case (p)
            0: bits = 100;
            1: bits = 180;
            2: bits = 20;
            default: bits = 30 + (i * 37) % 200;
          endcase
          do_mb(bits, (i * 1103 + p * 517) % 4096, (p == 3 && i == 17));
          if (i % 7 == 3) begin
            q0 = int'(qp_next);
            @(negedge clk);
            // R12
            chk("R12 idle qp_next", int'(qp_next), q0);
            chk("R12 idle mb_cnt", int'(mb_cnt), m_cnt);
          end
        end
        end_frame();
      end
    end

    // R6: upper bound capped at 51, init above it, QP pushed upward
    start_frame(55, 10, 60, 2, 0, 7);
    chk("R6 init clamped to 51", int'(qp_next), 51);
    for (int i = 0; i < 25; i++) do_mb(400, 100, 1'b0);
    end_frame();
    // R6: lower bound, undershoot with negative MAD offset
    start_frame(5, 12, 30, 1, 255, 8);
    chk("R6 init clamped to min", int'(qp_next), 12);
    for (int i = 0; i < 15; i++) do_mb(0, 0, 1'b0);
    end_frame();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule